// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block gathers 64 level-sensitive interrupt request lines into a single request toward the processor. Each source line is sampled into a pending register. A software-writable force register can raise any pending bit on its own. A 64-bit mask register decides which pending bits may reach the request output. The request output is high whenever at least one pending bit is not masked.

Software reaches the block through a 256-byte register window. Each write carries a size flag: byte or 32-bit word. The mask can be replaced one 32-bit half at a time. It can also be edited with two byte-wide strobe registers. Each strobe takes a 6-bit source index and changes only that one mask bit. Setting bit 6 of the written byte changes every mask bit at once instead. Reads are combinational from the address. A write the block does not accept is dropped, and an error pulse is raised for it.

Top module: `intc_top`

## Requirements
- R1: After reset, every mask bit is 1 and every pending and force bit is 0. As a result the request output `irq` is low.
- R2: On each clock, pending bit i is loaded with `src_i[i]` OR force bit i. Reads show the new value from the following cycle.
- R3: A word write (`wr_word`=1) to offset 0x0C loads `wdata` into mask bits 31:0. Mask bits 63:32 keep their value.
- R4: A word write to offset 0x08 loads `wdata` into mask bits 63:32. Mask bits 31:0 keep their value.
- R5: A byte write (`wr_word`=0) to offset 0x1C sets mask bits. If `wdata[6]` is 1, every mask bit becomes 1. If `wdata[6]` is 0, only the mask bit indexed by `wdata[5:0]` becomes 1. `wdata[7]` is ignored.
- R6: A byte write to offset 0x1D clears mask bits. If `wdata[6]` is 1, every mask bit becomes 0. If `wdata[6]` is 0, only the mask bit indexed by `wdata[5:0]` becomes 0. `wdata[7]` is ignored.
- R7: `irq` is high exactly when (pending AND NOT mask) is nonzero, computed from the registered state. It therefore changes one clock after a source change or an accepted write.
- R8: `rdata` returns the value at offset `addr`:
  - 0x00 returns pending bits 63:32 and 0x04 returns pending bits 31:0.
  - 0x08 returns mask bits 63:32 and 0x0C returns mask bits 31:0.
  - 0x10 returns force bits 63:32 and 0x14 returns force bits 31:0.
  - Every other offset, including 0x1C and 0x1D, reads as 0.
- R9: A word write to offset 0x10 loads force bits 63:32, and a word write to offset 0x14 loads force bits 31:0.
- R10: Some writes are not accepted:
  - any write to an offset outside {0x08, 0x0C, 0x10, 0x14, 0x1C, 0x1D};
  - a byte write to 0x08, 0x0C, 0x10 or 0x14;
  - a word write to 0x1C or 0x1D.
  Such a write leaves all state unchanged, and `err` is high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level-sensitive interrupt source lines |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_word | input | 1 | Write size: 1 = 32-bit word, 0 = byte (`wdata[7:0]`) |
| addr | input | 8 | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| err | output | 1 | One-cycle pulse after a write that was not accepted |
| irq | output | 1 | Interrupt request: any unmasked pending bit |

## Verification
The checker watches several properties on every cycle:
- `irq` is low on the first cycle after reset.
- `irq` is low right after a mask-all strobe.
- `irq` holds steady while the sources are steady and no write occurs.
- `err` appears only after a write, and a legal low-mask write never raises it.
- The strobe offsets read as zero.

Only the bench's scenarios show the rest:
- the exact bit changed by an indexed set or clear;
- that the other mask half is preserved by a half-word write;
- that the pending bits include force bits;
- that a rejected write leaves the registers untouched.

To show these, the bench compares every output with a behavioural model on every clock and reads the registers back.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int WIN_BYTES = 256;
    localparam int OFF_W     = $clog2(WIN_BYTES);

    localparam logic [OFF_W-1:0] OFF_PEND_HI  = 8'h00;
    localparam logic [OFF_W-1:0] OFF_PEND_LO  = 8'h04;
    localparam logic [OFF_W-1:0] OFF_MASK_HI  = 8'h08;
    localparam logic [OFF_W-1:0] OFF_MASK_LO  = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_FORCE_HI = 8'h10;
    localparam logic [OFF_W-1:0] OFF_FORCE_LO = 8'h14;
    localparam logic [OFF_W-1:0] OFF_MSET     = 8'h1C;
    localparam logic [OFF_W-1:0] OFF_MCLR     = 8'h1D;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK_HI,
        SEL_MASK_LO,
        SEL_FORCE_HI,
        SEL_FORCE_LO,
        SEL_MSET,
        SEL_MCLR
    } wsel_e;

    typedef struct packed {
        wsel_e sel;
        logic  bad;
    } wdec_t;

    // Map an offset and a size to a target register; flag illegal combinations.
    function automatic wdec_t decode_write(input logic [OFF_W-1:0] off, input logic word);
        wdec_t d;
        d.sel = SEL_NONE;
        d.bad = 1'b0;
        case (off)
            OFF_MASK_HI:  if (word) d.sel = SEL_MASK_HI;  else d.bad = 1'b1;
            OFF_MASK_LO:  if (word) d.sel = SEL_MASK_LO;  else d.bad = 1'b1;
            OFF_FORCE_HI: if (word) d.sel = SEL_FORCE_HI; else d.bad = 1'b1;
            OFF_FORCE_LO: if (word) d.sel = SEL_FORCE_LO; else d.bad = 1'b1;
            OFF_MSET:     if (!word) d.sel = SEL_MSET;    else d.bad = 1'b1;
            OFF_MCLR:     if (!word) d.sel = SEL_MCLR;    else d.bad = 1'b1;
            default:      d.bad = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/intc_wdecode.sv
module intc_wdecode
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_word,
    input  logic [OFF_W-1:0] addr,
    output wsel_e            sel,
    output logic             err_q
);
    wdec_t dec;

    always_comb begin
        dec = decode_write(addr, wr_word);
        sel = wr_en ? dec.sel : SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= wr_en & dec.bad;
    end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
    import intc_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  wsel_e             sel,
    input  logic [N_SRC/2-1:0] wdata,
    output logic [N_SRC-1:0]  mask_q
);
    localparam int HALF    = N_SRC / 2;
    localparam int IDX_W   = $clog2(N_SRC);
    localparam int ALL_POS = IDX_W;

    logic [IDX_W-1:0] idx;
    logic             all_bits;
    logic [N_SRC-1:0] hit;
    logic [N_SRC-1:0] mask_d;

    assign idx      = wdata[IDX_W-1:0];
    assign all_bits = wdata[ALL_POS];

    // One-hot select of the indexed source for single-bit edits.
    for (genvar i = 0; i < N_SRC; i++) begin : g_hit
        assign hit[i] = (idx == IDX_W'(i));
    end

    always_comb begin
        mask_d = mask_q;
        case (sel)
            SEL_MASK_HI: mask_d[N_SRC-1:HALF] = wdata;
            SEL_MASK_LO: mask_d[HALF-1:0]     = wdata;
            SEL_MSET:    mask_d = all_bits ? {N_SRC{1'b1}} : (mask_q | hit);
            SEL_MCLR:    mask_d = all_bits ? {N_SRC{1'b0}} : (mask_q & ~hit);
            default:     ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= {N_SRC{1'b1}};
        else     mask_q <= mask_d;
    end
endmodule

// File: rtl/intc_src_reg.sv
module intc_src_reg
    import intc_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SRC-1:0]   src_i,
    input  wsel_e              sel,
    input  logic [N_SRC/2-1:0] wdata,
    output logic [N_SRC-1:0]   pend_q,
    output logic [N_SRC-1:0]   force_q
);
    localparam int HALF = N_SRC / 2;

    logic [N_SRC-1:0] force_d;

    always_comb begin
        force_d = force_q;
        case (sel)
            SEL_FORCE_HI: force_d[N_SRC-1:HALF] = wdata;
            SEL_FORCE_LO: force_d[HALF-1:0]     = wdata;
            default:      ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            force_q <= '0;
        end else begin
            pend_q  <= src_i | force_q;
            force_q <= force_d;
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SRC-1:0]   src_i,
    input  logic               wr_en,
    input  logic               wr_word,
    input  logic [OFF_W-1:0]   addr,
    input  logic [N_SRC/2-1:0] wdata,
    output logic [N_SRC/2-1:0] rdata,
    output logic               err,
    output logic               irq
);
    localparam int HALF = N_SRC / 2;

    wsel_e            sel;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] force_q;

    intc_wdecode u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .addr    (addr),
        .sel     (sel),
        .err_q   (err)
    );

    intc_mask_reg #(.N_SRC(N_SRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .wdata  (wdata),
        .mask_q (mask_q)
    );

    intc_src_reg #(.N_SRC(N_SRC)) u_src (
        .clk     (clk),
        .rst     (rst),
        .src_i   (src_i),
        .sel     (sel),
        .wdata   (wdata),
        .pend_q  (pend_q),
        .force_q (force_q)
    );

    always_comb begin
        case (addr)
            OFF_PEND_HI:  rdata = pend_q[N_SRC-1:HALF];
            OFF_PEND_LO:  rdata = pend_q[HALF-1:0];
            OFF_MASK_HI:  rdata = mask_q[N_SRC-1:HALF];
            OFF_MASK_LO:  rdata = mask_q[HALF-1:0];
            OFF_FORCE_HI: rdata = force_q[N_SRC-1:HALF];
            OFF_FORCE_LO: rdata = force_q[HALF-1:0];
            default:      rdata = '0;
        endcase
    end

    assign irq = |(pend_q & ~mask_q);
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input logic               clk,
    input logic               rst,
    input logic [N_SRC-1:0]   src_i,
    input logic               wr_en,
    input logic               wr_word,
    input logic [OFF_W-1:0]   addr,
    input logic [N_SRC/2-1:0] wdata,
    input logic [N_SRC/2-1:0] rdata,
    input logic               err,
    input logic               irq
);
    localparam int ALL_POS = $clog2(N_SRC);

    // R1: no request on the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);

    // R10: an error pulse is always caused by a write one cycle earlier
    a_r10_err_follows_write: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(wr_en));

    // R10: a legal low-mask word write never raises an error
    a_r10_legal_no_err: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word && addr == OFF_MASK_LO) |=> !err);

    // R5: mask-all strobe silences the request
    a_r5_mask_all_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_word && addr == OFF_MSET && wdata[ALL_POS]) |=> !irq);

    // R8: strobe offsets read as zero
    a_r8_strobe_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == OFF_MSET || addr == OFF_MCLR) |-> rdata == '0);

    // R7: request holds while sources hold and no write occurs
    a_r7_irq_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2) && !$past(wr_en, 1) && !$past(wr_en, 2)
         && $past(src_i, 1) == $past(src_i, 2)) |-> $stable(irq));
endmodule

bind intc_top intc_chk #(.N_SRC(N_SRC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_i   (src_i),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .err     (err),
    .irq     (irq)
);

// File: tb/sim_intc_top.sv
`timescale 1ns/1ps
module sim_intc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_i = '0;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    intc_top u0 (
        .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .wr_word(wr_word),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
    );

    // Behavioural reference model
    logic [63:0] m_pend, m_mask, m_force;
    logic        m_err;

    function automatic bit legal(input logic [7:0] a, input logic w);
        if (a == 8'h08 || a == 8'h0C || a == 8'h10 || a == 8'h14) return w;
        if (a == 8'h1C || a == 8'h1D) return !w;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_pend[63:32];
            8'h04: return m_pend[31:0];
            8'h08: return m_mask[63:32];
            8'h0C: return m_mask[31:0];
            8'h10: return m_force[63:32];
            8'h14: return m_force[31:0];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [63:0] np, nm, nf;
        if (rst) begin
            m_pend = '0; m_mask = '1; m_force = '0; m_err = 0;
        end else begin
            np = src_i | m_force;
            nm = m_mask;
            nf = m_force;
            m_err = wr_en && !legal(addr, wr_word);
            if (wr_en && legal(addr, wr_word)) begin
                case (addr)
                    8'h08: nm[63:32] = wdata;
                    8'h0C: nm[31:0]  = wdata;
                    8'h10: nf[63:32] = wdata;
                    8'h14: nf[31:0]  = wdata;
                    8'h1C: if (wdata[6]) nm = '1; else nm[wdata[5:0]] = 1'b1;
                    8'h1D: if (wdata[6]) nm = '0; else nm[wdata[5:0]] = 1'b0;
                    default: ;
                endcase
            end
            m_pend = np; m_mask = nm; m_force = nf;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(irq === |(m_pend & ~m_mask), "R7 irq", {63'b0, irq}, {63'b0, |(m_pend & ~m_mask)});
            chk(err === m_err, "R10 err", {63'b0, err}, {63'b0, m_err});
            chk(rdata === m_read(addr), "R8 rdata", {32'b0, rdata}, {32'b0, m_read(addr)});
        end
    end

    task automatic wr(input logic [7:0] a, input logic w, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1; wr_word = w; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        addr = a;
        @(negedge clk);
        chk(rdata === exp, tag, {32'b0, rdata}, {32'b0, exp});
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        @(negedge clk);
        chk(irq === 1'b0, "R1 irq low", {63'b0, irq}, 64'h0);
        rd(8'h08, 32'hFFFF_FFFF, "R1 mask hi");
        rd(8'h0C, 32'hFFFF_FFFF, "R1 mask lo");
        rd(8'h04, 32'h0, "R1 pend lo");
        rd(8'h14, 32'h0, "R1 force lo");

        // R2 source sampled into pending
        @(posedge clk); #2 src_i = 64'h1;
        rd(8'h04, 32'h1, "R2 pend follows src");
        chk(irq === 1'b0, "R7 masked source quiet", {63'b0, irq}, 64'h0);

        // R6 indexed clear unmasks source 0
        wr(8'h1D, 0, 32'h0000_0000);
        @(negedge clk);
        chk(irq === 1'b1, "R7 irq after unmask", {63'b0, irq}, 64'h1);
        rd(8'h0C, 32'hFFFF_FFFE, "R6 clear bit0");

        // R5 indexed set, bit7 ignored
        wr(8'h1C, 0, 32'h0000_0080);
        rd(8'h0C, 32'hFFFF_FFFF, "R5 set bit0 bit7 ignored");
        chk(irq === 1'b0, "R5 irq after remask", {63'b0, irq}, 64'h0);

        // R3 / R4 half-word writes
        wr(8'h0C, 1, 32'h1234_5678);
        rd(8'h0C, 32'h1234_5678, "R3 low half loaded");
        rd(8'h08, 32'hFFFF_FFFF, "R3 high half kept");
        wr(8'h08, 1, 32'hA5A5_0000);
        rd(8'h08, 32'hA5A5_0000, "R4 high half loaded");
        rd(8'h0C, 32'h1234_5678, "R4 low half kept");

        // R6 clear all, R5 set all with index present
        wr(8'h1D, 0, 32'h0000_0040);
        rd(8'h08, 32'h0, "R6 clear all hi");
        rd(8'h0C, 32'h0, "R6 clear all lo");
        wr(8'h1C, 0, 32'h0000_0045);
        rd(8'h08, 32'hFFFF_FFFF, "R5 set all hi");
        rd(8'h0C, 32'hFFFF_FFFF, "R5 set all lo");

        // R6 clear bit 63, R9 force drives pending
        wr(8'h1D, 0, 32'h0000_003F);
        rd(8'h08, 32'h7FFF_FFFF, "R6 clear bit63");
        @(posedge clk); #2 src_i = '0;
        wr(8'h10, 1, 32'h8000_0000);
        rd(8'h10, 32'h8000_0000, "R9 force hi");
        rd(8'h00, 32'h8000_0000, "R2 pending from force");
        @(negedge clk);
        chk(irq === 1'b1, "R7 irq from force", {63'b0, irq}, 64'h1);
        wr(8'h10, 1, 32'h0);

        // R10 rejected writes
        wr(8'h1C, 1, 32'h0000_0040);
        @(negedge clk);
        chk(err === 1'b1, "R10 word to strobe errs", {63'b0, err}, 64'h1);
        @(negedge clk);
        chk(err === 1'b0, "R10 err single cycle", {63'b0, err}, 64'h0);
        rd(8'h0C, 32'hFFFF_FFFF, "R10 mask untouched");
        wr(8'h0C, 0, 32'h0);
        @(negedge clk);
        chk(err === 1'b1, "R10 byte to word reg errs", {63'b0, err}, 64'h1);
        wr(8'h40, 1, 32'h0);
        wr(8'h00, 1, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R10 pending not writable");
        rd(8'h0C, 32'hFFFF_FFFF, "R10 mask still untouched");

        // R8 zero reads
        rd(8'h1C, 32'h0, "R8 set strobe reads zero");
        rd(8'h1D, 32'h0, "R8 clear strobe reads zero");
        rd(8'h30, 32'h0, "R8 unmapped reads zero");

        // Mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #2;
            src_i = {$urandom, $urandom} & {$urandom, $urandom};
            wr_en = ($urandom % 3) == 0;
            case ($urandom % 9)
                0: addr = 8'h08; 1: addr = 8'h0C; 2: addr = 8'h10; 3: addr = 8'h14;
                4: addr = 8'h1C; 5: addr = 8'h1D; 6: addr = 8'h00; 7: addr = 8'h04;
                default: addr = 8'($urandom);
            endcase
            wr_word = (addr == 8'h1C || addr == 8'h1D) ? (($urandom % 4) == 0) : (($urandom % 4) != 0);
            wdata = $urandom;
        end
        @(posedge clk); #2 wr_en = 0;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule